// File: doc/BRIEF.md
# Optical Link Transmit Framer

This block runs entirely on the master clock of an optical voice transmitter. It divides that clock into a bit rate and a frame rate and reports both as single-cycle enables, together with level versions for an external codec. It drives one serial line toward the optical emitter. Each frame that line carries either a fixed 8-bit synchronisation word or the serial sample stream coming back from the codec.

The choice of source comes from two inputs. A manual mode pin asks for training. A feedback pin reports that the far end has lost the link, and it forces training whatever the mode pin says. The choice is sampled once per frame, near the frame boundary. It never changes in the middle of the early bit slots, so the receiver always sees whole words while it hunts for alignment. With the default parameters a 2.048 MHz master clock gives a 64 kHz bit rate and 8 kHz frames.

The serial interfaces are bit-synchronous and cannot be stalled, so there is no valid/ready handshake. Every pin is a plain control, status or serial signal.

Top module: `optx_tx_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bit_stb_o`, `bclk_o`, `fsync_o`, `frame_stb_o` and `training_o` are all 1. Reset is synchronous and active high.
- R2: `bit_stb_o` is high for exactly one cycle in every BIT_DIV (32) master cycles. That cycle is the first cycle of each bit slot.
- R3: `bclk_o` is high for the first BIT_DIV/2 (16) cycles of each bit slot and low for the rest, which gives a 50% duty cycle.
- R4: A frame is FRAME_BITS (8) slots, which is 256 cycles. `fsync_o` is high exactly during slot 0, a 12.5% duty cycle. `frame_stb_o` is high only in the first cycle of slot 0.
- R5: While training is selected, `line_o` in slot k equals bit (7-k) of TRAIN_WORD. The default word is 8'hA5 = 10100101, which is sent most significant bit first and reloaded every frame. The first and last bits of the word must be equal.
- R6: `training_o` (1 = training word, 0 = codec data) changes only at the start of slot 7. Its new value is (`link_lost_i` OR `mode_train_i`) as sampled in the last cycle of slot 6. Changes to either input at any other time have no effect on the source.
- R7: If `link_lost_i` is 1 when the choice is sampled, training is selected even when `mode_train_i` is 0.
- R8: While data is selected, `line_o` equals `pcm_data_i` in the same cycle.
- R9: A switch from training to data lets slot 7 of the last training frame carry the codec bit. A switch from data to training puts training bit 0 (a 1) into slot 7 of the last data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_train_i | input | 1 | Manual request for training words |
| link_lost_i | input | 1 | Far-end link-loss feedback, forces training |
| pcm_data_i | input | 1 | Serial sample data from the codec |
| bit_stb_o | output | 1 | One-cycle enable at the start of each bit slot |
| bclk_o | output | 1 | Bit clock level, 50% duty |
| frame_stb_o | output | 1 | One-cycle enable at the start of each frame |
| fsync_o | output | 1 | Frame sync level, high during slot 0 |
| line_o | output | 1 | Serial line toward the optical driver |
| training_o | output | 1 | High while the training word is the source |

## Verification
The first directed patterns hold training for several frames to show that the word repeats exactly. A switch to data then separates a source change at slot 7 from one made at the frame start. Forcing link loss while the mode pin asks for data shows that feedback overrides the manual choice. A short mode pulse placed mid-frame, clear of the sampling cycle, must leave the source unchanged. After these, long random runs toggle mode and feedback at arbitrary cycles under random codec bits. A reset in the middle of a frame confirms that every divider restarts at slot 0.

// File: rtl/optx_pkg.sv
package optx_pkg;
  typedef enum logic {
    SRC_DATA  = 1'b0,
    SRC_TRAIN = 1'b1
  } src_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/optx_clkgen.sv
module optx_clkgen #(
  parameter int unsigned BIT_DIV    = 32,
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  output logic bit_stb,
  output logic bit_end,
  output logic bclk,
  output logic fsync,
  output logic frame_stb,
  output logic last_slot,
  output logic decide_slot
);
  import optx_pkg::*;
  localparam int unsigned MW = cnt_w(BIT_DIV);
  localparam int unsigned FW = cnt_w(FRAME_BITS);
  localparam logic [MW-1:0] MLAST = MW'(BIT_DIV - 1);
  localparam logic [MW-1:0] MHALF = MW'(BIT_DIV / 2);
  localparam logic [FW-1:0] FLAST = FW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] FDEC  = FW'(FRAME_BITS - 2);

  logic [MW-1:0] mcnt_q;
  logic [FW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt_q <= '0;
      slot_q <= '0;
    end else if (mcnt_q == MLAST) begin
      mcnt_q <= '0;
      slot_q <= (slot_q == FLAST) ? '0 : slot_q + 1'b1;
    end else begin
      mcnt_q <= mcnt_q + 1'b1;
    end
  end

  always_comb begin
    bit_stb     = (mcnt_q == '0);
    bit_end     = (mcnt_q == MLAST);
    bclk        = (mcnt_q < MHALF);
    fsync       = (slot_q == '0);
    frame_stb   = bit_stb && fsync;
    last_slot   = (slot_q == FLAST);
    decide_slot = (slot_q == FDEC);
  end
endmodule

// File: rtl/optx_train_ser.sv
module optx_train_ser #(
  parameter int unsigned FRAME_BITS = 8,
  parameter logic [FRAME_BITS-1:0] TRAIN_WORD = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_end,
  input  logic last_slot,
  output logic tbit
);
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= TRAIN_WORD;
    end else if (bit_end) begin
      if (last_slot) sh_q <= TRAIN_WORD;
      else           sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign tbit = sh_q[FRAME_BITS-1];
endmodule

// File: rtl/optx_src_sel.sv
module optx_src_sel (
  input  logic            clk,
  input  logic            rst,
  input  logic            decide,
  input  logic            mode_train,
  input  logic            link_lost,
  output optx_pkg::src_e  src
);
  import optx_pkg::*;
  src_e src_q;

  always_ff @(posedge clk) begin
    if (rst)         src_q <= SRC_TRAIN;
    else if (decide) src_q <= (link_lost || mode_train) ? SRC_TRAIN : SRC_DATA;
  end

  assign src = src_q;
endmodule

// File: rtl/optx_tx_framer.sv
module optx_tx_framer #(
  parameter int unsigned BIT_DIV    = 32,
  parameter int unsigned FRAME_BITS = 8,
  parameter logic [FRAME_BITS-1:0] TRAIN_WORD = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_train_i,
  input  logic link_lost_i,
  input  logic pcm_data_i,
  output logic bit_stb_o,
  output logic bclk_o,
  output logic frame_stb_o,
  output logic fsync_o,
  output logic line_o,
  output logic training_o
);
  import optx_pkg::*;

  logic bit_end, last_slot, decide_slot, tbit;
  src_e src;

  optx_clkgen #(.BIT_DIV(BIT_DIV), .FRAME_BITS(FRAME_BITS)) u_clk (
    .clk(clk), .rst(rst),
    .bit_stb(bit_stb_o), .bit_end(bit_end), .bclk(bclk_o),
    .fsync(fsync_o), .frame_stb(frame_stb_o),
    .last_slot(last_slot), .decide_slot(decide_slot)
  );

  optx_train_ser #(.FRAME_BITS(FRAME_BITS), .TRAIN_WORD(TRAIN_WORD)) u_ser (
    .clk(clk), .rst(rst), .bit_end(bit_end), .last_slot(last_slot), .tbit(tbit)
  );

  optx_src_sel u_sel (
    .clk(clk), .rst(rst), .decide(bit_end && decide_slot),
    .mode_train(mode_train_i), .link_lost(link_lost_i), .src(src)
  );

  always_comb begin
    training_o = (src == SRC_TRAIN);
    line_o     = training_o ? tbit : pcm_data_i;
  end
endmodule

// File: rtl/optx_tx_framer_chk.sv
module optx_tx_framer_chk #(
  parameter int unsigned BIT_DIV = 32
) (
  input logic clk,
  input logic rst,
  input logic link_lost_i,
  input logic bit_stb_o,
  input logic bclk_o,
  input logic frame_stb_o,
  input logic fsync_o,
  input logic training_o
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (bit_stb_o) begin
      gap_q  <= 16'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 16'd1;
    end
  end

  a_r2_bit_spacing: assert property (@(posedge clk) disable iff (rst)
    (bit_stb_o && seen_q) |-> (gap_q == 16'(BIT_DIV)));

  a_r1_release_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (training_o && bit_stb_o && fsync_o && frame_stb_o && bclk_o));

  a_r3_bclk_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |-> bit_stb_o);

  a_r4_frame_strobe: assert property (@(posedge clk) disable iff (rst)
    frame_stb_o |-> (fsync_o && bit_stb_o));

  a_r4_fsync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> frame_stb_o);

  a_r6_switch_point: assert property (@(posedge clk) disable iff (rst)
    !$stable(training_o) |-> (bit_stb_o && !fsync_o));

  a_r7_lost_keeps_training: assert property (@(posedge clk) disable iff (rst)
    $fell(training_o) |-> !$past(link_lost_i));
endmodule

bind optx_tx_framer optx_tx_framer_chk #(.BIT_DIV(BIT_DIV)) u_chk (
  .clk(clk), .rst(rst), .link_lost_i(link_lost_i),
  .bit_stb_o(bit_stb_o), .bclk_o(bclk_o), .frame_stb_o(frame_stb_o),
  .fsync_o(fsync_o), .training_o(training_o)
);

// File: tb/sim_optx_tx_framer.sv
module sim_optx_tx_framer;
  localparam int BD = 32;
  localparam int FB = 8;
  localparam logic [7:0] TW = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_train_i = 1'b1;
  logic link_lost_i = 1'b0;
  logic pcm_data_i = 1'b0;
  logic bit_stb_o, bclk_o, frame_stb_o, fsync_o, line_o, training_o;

  optx_tx_framer u0 (
    .clk(clk), .rst(rst), .mode_train_i(mode_train_i), .link_lost_i(link_lost_i),
    .pcm_data_i(pcm_data_i), .bit_stb_o(bit_stb_o), .bclk_o(bclk_o),
    .frame_stb_o(frame_stb_o), .fsync_o(fsync_o), .line_o(line_o),
    .training_o(training_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int n = 0;
  bit sel_m = 1'b1;
  bit done = 1'b0;
  int cyc = 0;

  function automatic int phase(input int c); return c % BD; endfunction
  function automatic int slot(input int c);  return (c / BD) % FB; endfunction
  function automatic bit exp_line(input int c, input bit s, input bit d);
    return s ? TW[7 - slot(c)] : d;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, n, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst) begin
      n = 0; sel_m = 1'b1;
    end else begin
      if (phase(n) == BD - 1 && slot(n) == FB - 2) sel_m = link_lost_i | mode_train_i;
      n = n + 1;
    end
    chk(bit_stb_o,   phase(n) == 0, "R2 bit_stb");
    chk(bclk_o,      phase(n) < BD / 2, "R3 bclk");
    chk(fsync_o,     slot(n) == 0, "R4 fsync");
    chk(frame_stb_o, phase(n) == 0 && slot(n) == 0, "R4 frame_stb");
    chk(training_o,  sel_m, link_lost_i ? "R7 training" : "R6 training");
    chk(line_o, exp_line(n, sel_m, pcm_data_i),
        slot(n) == 7 ? "R9 line" : (sel_m ? "R5 line" : "R8 line"));
  endtask

  task automatic run(input int cycles, input bit rnd);
    for (int i = 0; i < cycles; i++) begin
      tick();
      pcm_data_i = 1'($urandom);
      if (rnd) begin
        if ($urandom % 300 == 0) mode_train_i = ~mode_train_i;
        if ($urandom % 500 == 0) link_lost_i  = ~link_lost_i;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    run(3, 1'b0);
    // R1: reset values seen before release
    chk(training_o & bit_stb_o & fsync_o & frame_stb_o & bclk_o, 1'b1, "R1 reset state");
    rst = 1'b0;
    run(3 * BD * FB, 1'b0);           // R5: pure training frames
    mode_train_i = 1'b0;
    run(3 * BD * FB, 1'b0);           // R9: switch to data
    link_lost_i = 1'b1;
    run(3 * BD * FB, 1'b0);           // R7: loss overrides mode
    link_lost_i = 1'b0;
    run(2 * BD * FB, 1'b0);           // R8: data passthrough
    run(2 * BD + 5, 1'b0);
    mode_train_i = 1'b1;              // R6: short mid-frame pulse ignored
    run(40, 1'b0);
    mode_train_i = 1'b0;
    chk(training_o, 1'b0, "R6 pulse ignored");
    run(2 * BD * FB, 1'b0);
    run(40 * BD * FB, 1'b1);          // random mode and loss toggles
    run(3 * BD + 7, 1'b0);
    rst = 1'b1;                        // R1: reset mid-frame
    run(2, 1'b0);
    chk(fsync_o & bit_stb_o & training_o, 1'b1, "R1 mid-run reset");
    rst = 1'b0;
    run(4 * BD * FB, 1'b1);
    finish_run();
  end
endmodule